// File: doc/BRIEF.md
# GPIO Port with Sticky Edge Capture

This block is a general-purpose I/O port of up to 32 bits that sits behind a small word-addressed register slave. Software writes an output value, chooses per pin whether the block drives it, and reads back the pin levels. It can also set or clear chosen output bits in a single write without a read-modify-write. Every input is resynchronised into the clock domain. Each input edge of the kind chosen at build time is latched into a sticky capture register. The capture bits are then masked into one level-sensitive interrupt line.

Three build-time parameters set the variant. `MODE` makes the port input-only, output-only or bidirectional. `EDGE` picks rising, falling or both edges. `BIT_CLEAR` decides how a write to the capture register clears it. With `BIT_CLEAR` set, each written 1 clears only its own bit. With it clear, any write empties the whole register. Registers that the chosen mode does not have ignore writes and read as zero. A read is combinational: `bus_rdata` carries the selected word in the cycle `bus_rd` is high and is zero otherwise.

Word addresses (byte offset / 4): 0 pin levels / output value, 1 drive enable, 2 interrupt enable, 3 capture, 4 bit-set (write-only), 5 bit-clear (write-only).

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the output value, the drive enables, the interrupt enables and the capture bits are all zero. In bidirectional mode `pin_oe` is therefore all zero. `irq` is low.
- R2: A write to word 0 loads the output register, which appears on `pin_out` after that clock edge. A read of word 0 returns `pin_in` as seen through a two-flop synchroniser, so a change becomes visible two rising edges later.
- R3: In bidirectional mode word 1 holds one drive-enable bit per pin (1 = drive). It reads back as written, and `pin_oe` equals it.
- R4: Writing a mask to word 4 sets those output bits (0x40 sets bit 6). Writing a mask to word 5 clears them (0x08 clears bit 3). Other bits keep their value, and both words read as zero.
- R5: A capture bit becomes 1 on the third rising edge after its input makes a qualifying transition. It stays 1, whatever the pin does later, until software clears it.
- R6: With `BIT_CLEAR`=1, writing word 3 clears only the bits written as 1. With `BIT_CLEAR`=0, any write to word 3 clears every capture bit.
- R7: A qualifying edge in the same cycle as a clear of its bit wins, and the bit stays 1.
- R8: Word 2 holds the interrupt enables. `irq` is high exactly when some capture bit and its enable are both 1.
- R9: In input-only mode, writes to words 0, 1, 4 and 5 have no effect. `pin_out` and `pin_oe` stay zero, and word 1 reads as zero.
- R10: In output-only mode `pin_oe` is all ones, word 0 and word 3 read as zero, and `irq` stays low regardless of pin activity.
- R11: `EDGE` selects the qualifying transition: 0→1 for rising, 1→0 for falling, either for both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address of the register |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when `bus_rd` is low |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Output register value |
| pin_oe | output | WIDTH | Per-pin drive enable for the pad tristate |
| irq | output | 1 | Interrupt: any enabled capture bit set |

## Verification
Writes to words 0, 1, 2, 4 and 5 take effect at the edge that samples `bus_wr`. The bench therefore checks `pin_out`, `pin_oe` and `irq` at the falling edge that follows. A pin change made at a falling edge shows up in word 0 after two rising edges and in the capture register after three. The bench probes at the two-edge point to confirm that capture has not yet set, then again one edge later. For the edge-versus-clear race, the clearing write is timed to land on exactly that third edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Port direction variant fixed at build time
    typedef enum logic [1:0] {
        PORT_IN    = 2'd0,
        PORT_OUT   = 2'd1,
        PORT_BIDIR = 2'd2
    } port_mode_e;

    // Transition that sets a capture bit
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2
    } edge_kind_e;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 3;

    // Word addresses (byte offset divided by four)
    localparam logic [ADDR_W-1:0] WA_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] WA_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] WA_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] WA_CAP  = 3'd3;
    localparam logic [ADDR_W-1:0] WA_SET  = 3'd4;
    localparam logic [ADDR_W-1:0] WA_CLR  = 3'd5;

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser, one history flop and the edge qualifier.
module gpio_in_sync
    import gpio_edge_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter edge_kind_e  EDGE  = EDGE_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] edge_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
        logic [WIDTH-1:0] hist;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.sync = st_q.meta;
        st_d.hist = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.sync;

    generate
        if (EDGE == EDGE_RISE) begin : g_rise
            assign edge_o = st_q.sync & ~st_q.hist;
        end else if (EDGE == EDGE_FALL) begin : g_fall
            assign edge_o = ~st_q.sync & st_q.hist;
        end else begin : g_both
            assign edge_o = st_q.sync ^ st_q.hist;
        end
    endgenerate

    // A single-polarity edge can never be flagged on two cycles in a row
    generate
        if (EDGE != EDGE_BOTH) begin : g_chk_single
            assert_edge_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_o & $past(edge_o)) == '0)
                else $error("edge flagged on consecutive cycles");
        end
    endgenerate

endmodule

// File: rtl/gpio_edge_cap.sv
// Sticky capture register, interrupt enables and interrupt reduction.
module gpio_edge_cap #(
    parameter int unsigned WIDTH     = 8,
    parameter bit          ENABLE    = 1'b1,
    parameter bit          BIT_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] edge_i,
    input  logic             cap_wr_i,
    input  logic             mask_wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] cap_o,
    output logic [WIDTH-1:0] mask_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [WIDTH-1:0] cap;
        logic [WIDTH-1:0] mask;
    } cap_state_t;

    cap_state_t       st_d, st_q;
    logic [WIDTH-1:0] clr_mask;

    generate
        if (BIT_CLEAR) begin : g_w1c
            assign clr_mask = cap_wr_i ? wdata_i : '0;
        end else begin : g_clr_all
            assign clr_mask = cap_wr_i ? '1 : '0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (mask_wr_i) st_d.mask = wdata_i;
        if (ENABLE) begin
            // new edge is ORed in after the clear, so it wins a collision
            st_d.cap = (st_q.cap & ~clr_mask) | edge_i;
        end else begin
            st_d.cap = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o  = st_q.cap;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.cap & st_q.mask);

    // Captured bits survive every cycle in which they are not cleared
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cap & $past(st_q.cap & ~clr_mask)) == $past(st_q.cap & ~clr_mask)))
        else $error("capture bit lost without a clear");

    // A detected edge always lands in the register, even under a clear
    generate
        if (ENABLE) begin : g_chk_win
            assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ((st_q.cap & $past(edge_i)) == $past(edge_i)))
                else $error("edge dropped by a concurrent clear");
        end
    endgenerate

endmodule

// File: rtl/gpio_out_ctrl.sv
// Output value, drive enables and the set/clear update paths.
module gpio_out_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter port_mode_e  MODE  = PORT_BIDIR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr_i,
    input  logic             dir_wr_i,
    input  logic             set_wr_i,
    input  logic             clr_wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] out_o,
    output logic [WIDTH-1:0] dir_o,
    output logic [WIDTH-1:0] oe_o
);

    localparam bit HAS_OUT = (MODE != PORT_IN);
    localparam bit HAS_DIR = (MODE == PORT_BIDIR);

    typedef struct packed {
        logic [WIDTH-1:0] out;
        logic [WIDTH-1:0] dir;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (HAS_OUT) begin
            if (data_wr_i) st_d.out = wdata_i;
            if (set_wr_i)  st_d.out = st_q.out | wdata_i;
            if (clr_wr_i)  st_d.out = st_q.out & ~wdata_i;
        end
        if (HAS_DIR && dir_wr_i) st_d.dir = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q.out;
    assign dir_o = st_q.dir;

    generate
        if (MODE == PORT_BIDIR) begin : g_oe_dir
            assign oe_o = st_q.dir;
        end else if (MODE == PORT_OUT) begin : g_oe_all
            assign oe_o = '1;
        end else begin : g_oe_none
            assign oe_o = '0;
        end
    endgenerate

    generate
        if (HAS_OUT) begin : g_chk_out
            assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $past(set_wr_i) |-> ((st_q.out & $past(wdata_i)) == $past(wdata_i)))
                else $error("set write left a bit low");
            assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $past(clr_wr_i) |-> ((st_q.out & $past(wdata_i)) == '0))
                else $error("clear write left a bit high");
        end else begin : g_chk_in
            assert_input_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(st_q.out) && $stable(st_q.dir))
                else $error("input-only port changed its output state");
        end
    endgenerate

    assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dir_wr_i) |-> $stable(st_q.dir))
        else $error("drive enables moved without a write");

endmodule

// File: rtl/gpio_edge_port.sv
// Top: register decode, read mux and the three sub-blocks.
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int unsigned WIDTH     = 8,
    parameter port_mode_e  MODE      = PORT_BIDIR,
    parameter edge_kind_e  EDGE      = EDGE_RISE,
    parameter bit          BIT_CLEAR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);

    localparam bit HAS_IN  = (MODE != PORT_OUT);
    localparam bit HAS_DIR = (MODE == PORT_BIDIR);

    logic [WIDTH-1:0] wdata_w;
    logic [WIDTH-1:0] level_w, edge_w, cap_w, mask_w, out_w, dir_w;
    logic [WIDTH-1:0] rd_sel;
    logic             wr_data, wr_dir, wr_mask, wr_cap, wr_set, wr_clr;
    logic             unused_wdata;

    assign wdata_w      = bus_wdata[WIDTH-1:0];
    assign unused_wdata = ^bus_wdata;

    assign wr_data = bus_wr && (bus_addr == WA_DATA);
    assign wr_dir  = bus_wr && (bus_addr == WA_DIR);
    assign wr_mask = bus_wr && (bus_addr == WA_MASK);
    assign wr_cap  = bus_wr && (bus_addr == WA_CAP);
    assign wr_set  = bus_wr && (bus_addr == WA_SET);
    assign wr_clr  = bus_wr && (bus_addr == WA_CLR);

    gpio_in_sync #(.WIDTH(WIDTH), .EDGE(EDGE)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_in),
        .level_o (level_w),
        .edge_o  (edge_w)
    );

    gpio_edge_cap #(.WIDTH(WIDTH), .ENABLE(HAS_IN), .BIT_CLEAR(BIT_CLEAR)) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (HAS_IN ? edge_w : '0),
        .cap_wr_i  (wr_cap),
        .mask_wr_i (wr_mask),
        .wdata_i   (wdata_w),
        .cap_o     (cap_w),
        .mask_o    (mask_w),
        .irq_o     (irq)
    );

    gpio_out_ctrl #(.WIDTH(WIDTH), .MODE(MODE)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr_i (wr_data),
        .dir_wr_i  (wr_dir),
        .set_wr_i  (wr_set),
        .clr_wr_i  (wr_clr),
        .wdata_i   (wdata_w),
        .out_o     (out_w),
        .dir_o     (dir_w),
        .oe_o      (pin_oe)
    );

    assign pin_out = out_w;

    always_comb begin
        rd_sel = '0;
        if (bus_rd) begin
            case (bus_addr)
                WA_DATA: rd_sel = HAS_IN  ? level_w : '0;
                WA_DIR:  rd_sel = HAS_DIR ? dir_w   : '0;
                WA_MASK: rd_sel = mask_w;
                WA_CAP:  rd_sel = HAS_IN  ? cap_w   : '0;
                default: rd_sel = '0;
            endcase
        end
    end

    assign bus_rdata = BUS_W'(rd_sel);

    // The interrupt can only be high while some enable bit is set
    assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_w != '0))
        else $error("interrupt raised with all enables clear");

    // Nothing is returned on the read bus outside a read strobe
    assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0))
        else $error("read data driven without a read");

endmodule

// File: tb/gpio_edge_port_tb.sv
`timescale 1ns/1ps
module gpio_edge_port_tb_top;
    import gpio_edge_pkg::*;

    localparam int W = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    addr = '0;
    logic          rd = 1'b0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [W-1:0]  pins = '0;

    // A: bidir/rise/per-bit  B: input/both/clear-all  C: output  D: bidir/fall
    logic [31:0]   rdata_a, rdata_b, rdata_c, rdata_d;
    logic [W-1:0]  out_a, out_b, out_c, out_d;
    logic [W-1:0]  oe_a, oe_b, oe_c, oe_d;
    logic          irq_a, irq_b, irq_c, irq_d;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    gpio_edge_port #(.WIDTH(W), .MODE(PORT_BIDIR), .EDGE(EDGE_RISE), .BIT_CLEAR(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .pin_in(pins),
        .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

    gpio_edge_port #(.WIDTH(W), .MODE(PORT_IN), .EDGE(EDGE_BOTH), .BIT_CLEAR(1'b0)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .pin_in(pins),
        .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

    gpio_edge_port #(.WIDTH(W), .MODE(PORT_OUT), .EDGE(EDGE_RISE), .BIT_CLEAR(1'b1)) dut_c_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata_c), .pin_in(pins),
        .pin_out(out_c), .pin_oe(oe_c), .irq(irq_c));

    gpio_edge_port #(.WIDTH(W), .MODE(PORT_BIDIR), .EDGE(EDGE_FALL), .BIT_CLEAR(1'b1)) dut_d_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata_d), .pin_in(pins),
        .pin_out(out_d), .pin_oe(oe_d), .irq(irq_d));

    // word, write value, expected output register, expected drive enables (bidir)
    typedef struct packed {
        logic [2:0]   word;
        logic [7:0]   val;
        logic [7:0]   exp_out;
        logic [7:0]   exp_oe;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 8'h3C, 8'h3C, 8'h00},
        '{3'd1, 8'h0F, 8'h3C, 8'h0F},
        '{3'd4, 8'h40, 8'h7C, 8'h0F},
        '{3'd5, 8'h08, 8'h74, 8'h0F},
        '{3'd4, 8'h81, 8'hF5, 8'h0F},
        '{3'd5, 8'hF0, 8'h05, 8'h0F},
        '{3'd1, 8'hFF, 8'h05, 8'hFF},
        '{3'd0, 8'h5A, 8'h5A, 8'hFF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] w, input logic [31:0] v);
        @(negedge clk);
        rd = 1'b0; addr = w; wdata = v; wr = 1'b1;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] w);
        @(negedge clk);
        wr = 1'b0; addr = w; rd = 1'b1;
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int w = 0; w < 6; w++) begin
            peek(3'(w));
            chk($sformatf("R1 reset word %0d", w), rdata_a, 32'h0);
        end
        chk("R1 reset pin_oe", {24'h0, oe_a}, 32'h0);
        chk("R1 reset pin_out", {24'h0, out_a}, 32'h0);
        chk("R1 reset irq", {31'h0, irq_a}, 32'h0);
        chk("R10 output-only oe", {24'h0, oe_c}, 32'hFF);

        // Table: R2 R3 R4 on bidir, R9 input-only, R10 output-only
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i].word, {24'h0, VECS[i].val});
            peek(3'd0);
            chk($sformatf("R4 R2 vec %0d pin_out", i), {24'h0, out_a}, {24'h0, VECS[i].exp_out});
            chk($sformatf("R3 vec %0d pin_oe", i), {24'h0, oe_a}, {24'h0, VECS[i].exp_oe});
            chk($sformatf("R11 fall-variant vec %0d pin_out", i), {24'h0, out_d}, {24'h0, VECS[i].exp_out});
            chk($sformatf("R9 vec %0d pin_out", i), {24'h0, out_b}, 32'h0);
            chk($sformatf("R9 vec %0d pin_oe", i), {24'h0, oe_b}, 32'h0);
            chk($sformatf("R10 vec %0d pin_out", i), {24'h0, out_c}, {24'h0, VECS[i].exp_out});
            chk($sformatf("R10 vec %0d pin_oe", i), {24'h0, oe_c}, 32'hFF);
        end

        peek(3'd1);
        chk("R3 direction readback", rdata_a, 32'hFF);
        chk("R9 direction reads zero", rdata_b, 32'h0);
        peek(3'd4);
        chk("R4 set word reads zero", rdata_a, 32'h0);
        peek(3'd5);
        chk("R4 clear word reads zero", rdata_a, 32'h0);

        // R5 latency: rise on bit 0
        @(negedge clk); pins = 8'h01;
        repeat (2) @(posedge clk);
        peek(3'd3);
        chk("R5 capture not yet set at two edges", rdata_a, 32'h0);
        peek(3'd0);
        chk("R2 synchronised level", rdata_a, 32'h01);
        chk("R10 data reads zero", rdata_c, 32'h0);
        peek(3'd3);
        chk("R5 capture set at third edge", rdata_a, 32'h01);
        chk("R11 both-edge capture on rise", rdata_b, 32'h01);
        chk("R11 fall capture ignores rise", rdata_d, 32'h0);
        chk("R10 capture reads zero", rdata_c, 32'h0);

        // R8 interrupt enable
        chk("R8 irq low with mask clear", {31'h0, irq_a}, 32'h0);
        bus_write(3'd2, 32'h01);
        peek(3'd2);
        chk("R8 mask readback", rdata_a, 32'h01);
        chk("R8 irq high", {31'h0, irq_a}, 32'h1);
        chk("R8 irq high input-only", {31'h0, irq_b}, 32'h1);
        chk("R10 irq stays low", {31'h0, irq_c}, 32'h0);

        // fall on bit 0
        @(negedge clk); pins = 8'h00;
        repeat (3) @(posedge clk);
        peek(3'd3);
        chk("R5 sticky after pin drops", rdata_a, 32'h01);
        chk("R11 fall capture", rdata_d, 32'h01);
        chk("R11 both-edge still set", rdata_b, 32'h01);

        // R6 per-bit vs clear-all
        bus_write(3'd3, 32'h02);
        peek(3'd3);
        chk("R6 per-bit clear keeps other bit", rdata_a, 32'h01);
        chk("R6 clear-all empties register", rdata_b, 32'h0);
        chk("R8 irq drops with capture", {31'h0, irq_b}, 32'h0);
        chk("R8 irq kept", {31'h0, irq_a}, 32'h1);
        bus_write(3'd3, 32'h01);
        peek(3'd3);
        chk("R6 per-bit clear of set bit", rdata_a, 32'h0);
        chk("R6 per-bit clear fall variant", rdata_d, 32'h0);
        chk("R8 irq low after clear", {31'h0, irq_a}, 32'h0);

        // two rising bits
        @(negedge clk); pins = 8'h03;
        repeat (3) @(posedge clk);
        peek(3'd3);
        chk("R5 two bits captured", rdata_a, 32'h03);
        chk("R11 both-edge two bits", rdata_b, 32'h03);
        chk("R11 fall capture ignores rises", rdata_d, 32'h0);

        // R7 collision: bit 0 falls, clear of bit 0 lands on the capture edge
        @(negedge clk); pins = 8'h02;
        repeat (2) @(posedge clk);
        bus_write(3'd3, 32'h01);
        peek(3'd3);
        chk("R7 no edge: bit cleared", rdata_a, 32'h02);
        chk("R7 edge wins per-bit clear", rdata_d, 32'h01);
        chk("R7 edge wins clear-all", rdata_b, 32'h01);

        @(negedge clk); rd = 1'b0;
        finish_run();
    end

endmodule